// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write-Unlock Key

This block is a watchdog timer driven by a simple synchronous register port. Software loads two preload values, one for each stage, selects the prescale range and the reset behaviour, and then enables the timer. Once enabled, the timer counts down the first stage. When the first stage runs out, the block raises a stage-one flag, loads the second preload and keeps counting. If software does not restart the timer before the second stage also runs out, the block sets a sticky timeout flag. It can also request a warm or cold system reset for a fixed number of cycles, and it can toggle an auxiliary output.

The preload registers and the restart/clear byte are protected. A write to any of them is accepted only when it comes directly after a two-byte key written to the key byte. A sticky lock bit freezes the enable bit, the lock bit itself and the control byte until the next hardware reset. Once the timer is enabled and locked, software has no way to stop it.

The bus uses word addresses with byte enables. The key byte is lane 0 of word 3 and the restart/clear byte is lane 1 of the same word. Reads return data one cycle after the address is presented.

Top module: `wdt2_core`

## Requirements
- R1: After a synchronous reset, every register, both flags, the reset request, the warm indication, the auxiliary output and the read data are 0.
- R2: A write to word 0 (stage-one preload, bits 19:0), word 1 (stage-two preload, bits 19:0), or word 3 with byte enable bit 1 set (the restart/clear byte) takes effect only if the two writes just before it were 0x80 and then 0x86, each written to word 3 with byte enables exactly 0001. Any other such write leaves the register and the timer unchanged.
- R3: The key state goes back to idle on any write that does not continue the key sequence, including a wrong value. An open key is used up by the very next write, whatever that write is.
- R4: In an accepted write to the restart/clear byte, data bit 8 restarts stage one from its preload and clears the stage-one flag, and data bit 9 clears the timeout flag. Both actions can be requested in the same write.
- R5: A stage with preload P lasts (P+1)·2^S cycles, where S is the PRE_SHIFT parameter. When control bit 2 is set, the stage lasts P+1 cycles instead.
- R6: When stage one runs out, the stage-one flag is set and stage two starts from its own preload.
- R7: When stage two runs out, the timeout flag is set and stage one starts again. If control bit 4 is set, the reset request is driven high for RST_CYCLES cycles, and the warm indication follows control bit 3 during that pulse. The auxiliary output toggles unless control bit 5 is set.
- R8: Word 6 bit 1 enables the timer. While this bit is 0, the stage is one and the counter is held at the stage-one preload, so no flag changes. Setting the bit starts stage one fresh.
- R9: Word 6 bit 0 is a lock bit. Once it is written as 1, it stays set, and writes to word 6 and to the control byte (word 4, bits 5:2) are ignored until reset.
- R10: The read data, one cycle after the address, is: the preloads on words 0 and 1; the timeout flag on bit 9 and the stage-one flag on bit 10 of word 3; control bits 5:2 on word 4; the free 32-bit configuration word, written per byte lane, on word 5; the enable and lock bits on word 6; and 0 on every other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the timer and for the register port |
| rst | input | 1 | Synchronous active-high reset |
| bus_word | input | WORD_W | Word index of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 4 | Byte-lane enables for a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the word presented one cycle earlier |
| stage1_irq_o | output | 1 | Stage-one expiry flag |
| timeout_o | output | 1 | Sticky final-timeout flag |
| rst_req_o | output | 1 | Reset request pulse |
| rst_warm_o | output | 1 | High during a reset request pulse that asks for a warm reset |
| aux_o | output | 1 | Auxiliary output, toggled at timeout |

## Verification
Every register, flag and output changes on the first clock edge after the write or expiry that causes it. Read data appears on the edge after the word is presented. The bench model advances on the same edge and both are compared at the following falling edge. The stage-one flag rises (P1+1)·2^S edges after the edge that enables the timer, and the timeout flag and reset pulse follow (P2+1)·2^S edges later. The directed checks count these edges from the return of the enabling write. The reset request then stays high for exactly RST_CYCLES compared cycles.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  localparam int BUS_W  = 32;
  localparam int LANES  = BUS_W / 8;
  localparam int PRE_W  = 20;

  // word map
  localparam int W_PRE1 = 0;
  localparam int W_PRE2 = 1;
  localparam int W_KEY  = 3;   // lane 0: key byte, lane 1: restart/clear byte
  localparam int W_CTRL = 4;
  localparam int W_CFG  = 5;
  localparam int W_LOCK = 6;

  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;

  // control field sits at data bits 5:2; indices below are within the field
  localparam int CTRL_LSB  = 2;
  localparam int CB_FAST   = 0;
  localparam int CB_WARM   = 1;
  localparam int CB_RSTEN  = 2;
  localparam int CB_NOTOG  = 3;

  localparam int RB_RESTART = 8;
  localparam int RB_CLRTO   = 9;

  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} key_state_e;
  typedef enum logic {ST_ONE, ST_TWO} stage_e;

  function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] cur,
                                                  input logic [BUS_W-1:0] nxt,
                                                  input logic [LANES-1:0] be);
    logic [BUS_W-1:0] r;
    r = cur;
    for (int i = 0; i < LANES; i++)
      if (be[i]) r[8*i +: 8] = nxt[8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/wdt2_unlock.sv
module wdt2_unlock
  import wdt2_pkg::*;
#(
  parameter int WORD_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [WORD_W-1:0] word,
  input  logic [LANES-1:0]  be,
  input  logic [7:0]        byte0,
  output logic              open_o
);
  key_state_e st_q;
  logic       key_wr;

  assign key_wr = (word == WORD_W'(W_KEY)) && (be == LANES'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= UL_IDLE;
    end else if (wr) begin
      if (key_wr && byte0 == KEY_FIRST)
        st_q <= UL_HALF;
      else if (key_wr && byte0 == KEY_SECOND && st_q == UL_HALF)
        st_q <= UL_OPEN;
      else
        st_q <= UL_IDLE;
    end
  end

  assign open_o = (st_q == UL_OPEN);
endmodule

// File: rtl/wdt2_downcount.sv
module wdt2_downcount #(
  parameter int PRE_W = 20,
  parameter int SHIFT = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             fast,
  input  logic [PRE_W-1:0] load_val,
  output logic             zero_o
);
  localparam int CW = PRE_W + SHIFT;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] slow_val;
  logic [CW-1:0] load_full;

  generate
    if (SHIFT == 0) begin : g_noshift
      assign slow_val = load_val;
    end else begin : g_shift
      assign slow_val = {load_val, {SHIFT{1'b1}}};
    end
  endgenerate

  assign load_full = fast ? CW'(load_val) : slow_val;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_full;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/wdt2_core.sv
module wdt2_core
  import wdt2_pkg::*;
#(
  parameter int PRE_SHIFT  = 15,
  parameter int RST_CYCLES = 4,
  parameter int WORD_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] bus_word,
  input  logic              bus_we,
  input  logic [LANES-1:0]  bus_be,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              stage1_irq_o,
  output logic              timeout_o,
  output logic              rst_req_o,
  output logic              rst_warm_o,
  output logic              aux_o
);
  localparam int PULSE_W = $clog2(RST_CYCLES + 1);

  logic [PRE_W-1:0]   pre1_q, pre2_q;
  logic [3:0]         ctrl_q;
  logic [BUS_W-1:0]   cfg_q;
  logic               lock_q, en_q;
  stage_e             stage_q;
  logic               irq_q, tout_q, warm_q, aux_q;
  logic [PULSE_W-1:0] pulse_q;
  logic [BUS_W-1:0]   rdata_q, rd_next;

  logic unl_open, cnt_zero;
  logic hit_pre1, hit_pre2, hit_key, hit_ctrl, hit_cfg, hit_lock;
  logic wr_pre1, wr_pre2, wr_rld, wr_ctrl, wr_cfg, wr_lock;
  logic restart, clr_to, expire, exp_one, exp_two, cnt_load;
  logic ctrl_rsten, in_stage_two;
  logic [PRE_W-1:0] load_val;

  assign hit_pre1 = bus_word == WORD_W'(W_PRE1);
  assign hit_pre2 = bus_word == WORD_W'(W_PRE2);
  assign hit_key  = bus_word == WORD_W'(W_KEY);
  assign hit_ctrl = bus_word == WORD_W'(W_CTRL);
  assign hit_cfg  = bus_word == WORD_W'(W_CFG);
  assign hit_lock = bus_word == WORD_W'(W_LOCK);

  wdt2_unlock #(.WORD_W(WORD_W)) u_unlock (
    .clk    (clk),
    .rst    (rst),
    .wr     (bus_we),
    .word   (bus_word),
    .be     (bus_be),
    .byte0  (bus_wdata[7:0]),
    .open_o (unl_open)
  );

  // protected writes need an open key; everything else goes straight in
  assign wr_pre1 = bus_we && hit_pre1 && unl_open;
  assign wr_pre2 = bus_we && hit_pre2 && unl_open;
  assign wr_rld  = bus_we && hit_key && bus_be[1] && unl_open;
  assign wr_ctrl = bus_we && hit_ctrl && bus_be[0] && !lock_q;
  assign wr_lock = bus_we && hit_lock && bus_be[0] && !lock_q;
  assign wr_cfg  = bus_we && hit_cfg;

  assign restart = wr_rld && bus_wdata[RB_RESTART];
  assign clr_to  = wr_rld && bus_wdata[RB_CLRTO];

  assign ctrl_rsten   = ctrl_q[CB_RSTEN];
  assign in_stage_two = (stage_q == ST_TWO);

  // expiry yields to a restart in the same cycle
  assign expire   = en_q && cnt_zero && !restart;
  assign exp_one  = expire && !in_stage_two;
  assign exp_two  = expire && in_stage_two;
  assign cnt_load = !en_q || restart || expire;
  assign load_val = exp_one ? pre2_q : pre1_q;

  wdt2_downcount #(.PRE_W(PRE_W), .SHIFT(PRE_SHIFT)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .fast     (ctrl_q[CB_FAST]),
    .load_val (load_val),
    .zero_o   (cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pre1_q <= '0;
      pre2_q <= '0;
      ctrl_q <= '0;
      cfg_q  <= '0;
      lock_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (wr_pre1) pre1_q <= PRE_W'(lane_merge(BUS_W'(pre1_q), bus_wdata, bus_be));
      if (wr_pre2) pre2_q <= PRE_W'(lane_merge(BUS_W'(pre2_q), bus_wdata, bus_be));
      if (wr_cfg)  cfg_q  <= lane_merge(cfg_q, bus_wdata, bus_be);
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_LSB +: 4];
      if (wr_lock) begin
        lock_q <= bus_wdata[0];
        en_q   <= bus_wdata[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= ST_ONE;
      irq_q   <= 1'b0;
      tout_q  <= 1'b0;
      pulse_q <= '0;
      warm_q  <= 1'b0;
      aux_q   <= 1'b0;
    end else begin
      if (!en_q || restart) stage_q <= ST_ONE;
      else if (exp_one)     stage_q <= ST_TWO;
      else if (exp_two)     stage_q <= ST_ONE;

      if (exp_one)      irq_q <= 1'b1;
      else if (restart) irq_q <= 1'b0;

      if (exp_two)     tout_q <= 1'b1;
      else if (clr_to) tout_q <= 1'b0;

      if (exp_two && ctrl_rsten) begin
        pulse_q <= PULSE_W'(RST_CYCLES);
        warm_q  <= ctrl_q[CB_WARM];
      end else if (pulse_q != '0) begin
        pulse_q <= pulse_q - 1'b1;
      end

      if (exp_two && !ctrl_q[CB_NOTOG]) aux_q <= ~aux_q;
    end
  end

  always_comb begin
    rd_next = '0;
    case (bus_word)
      WORD_W'(W_PRE1): rd_next = BUS_W'(pre1_q);
      WORD_W'(W_PRE2): rd_next = BUS_W'(pre2_q);
      WORD_W'(W_KEY):  rd_next = BUS_W'({irq_q, tout_q}) << RB_CLRTO;
      WORD_W'(W_CTRL): rd_next = BUS_W'(ctrl_q) << CTRL_LSB;
      WORD_W'(W_CFG):  rd_next = cfg_q;
      WORD_W'(W_LOCK): rd_next = BUS_W'({en_q, lock_q});
      default:         rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign bus_rdata    = rdata_q;
  assign stage1_irq_o = irq_q;
  assign timeout_o    = tout_q;
  assign rst_req_o    = (pulse_q != '0);
  assign rst_warm_o   = rst_req_o && warm_q;
  assign aux_o        = aux_q;
endmodule

// File: rtl/wdt2_core_chk.sv
module wdt2_core_chk (
  input logic clk,
  input logic rst,
  input logic lock_q,
  input logic en_q,
  input logic unl_open,
  input logic bus_we,
  input logic irq_q,
  input logic in_stage_two,
  input logic rst_req_o,
  input logic ctrl_rsten
);
  // R9: lock never falls back before reset
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);

  // R9: enable is frozen while locked
  a_r9_enable_frozen: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(en_q));

  // R3: an open key serves one write only
  a_r3_key_single_use: assert property (@(posedge clk) disable iff (rst)
    (unl_open && bus_we) |=> !unl_open);

  // R6: the stage-one flag rises together with entry into stage two
  a_r6_irq_enters_stage_two: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> in_stage_two);

  // R7: a reset pulse starts only when the reset enable was set
  a_r7_pulse_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req_o) |-> $past(ctrl_rsten));

  // R8: a disabled timer sits in stage one
  a_r8_idle_in_stage_one: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !in_stage_two);
endmodule

bind wdt2_core wdt2_core_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .lock_q       (lock_q),
  .en_q         (en_q),
  .unl_open     (unl_open),
  .bus_we       (bus_we),
  .irq_q        (irq_q),
  .in_stage_two (in_stage_two),
  .rst_req_o    (rst_req_o),
  .ctrl_rsten   (ctrl_rsten)
);

// File: tb/wdt2_core_test.sv
module wdt2_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int SHIFT      = 2;
  localparam int RSTC       = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_word = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        stage1_irq_o, timeout_o, rst_req_o, rst_warm_o, aux_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt2_core #(.PRE_SHIFT(SHIFT), .RST_CYCLES(RSTC), .WORD_W(3)) uut (
    .clk(clk), .rst(rst), .bus_word(bus_word), .bus_we(bus_we), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stage1_irq_o(stage1_irq_o),
    .timeout_o(timeout_o), .rst_req_o(rst_req_o), .rst_warm_o(rst_warm_o), .aux_o(aux_o)
  );

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int          m_pre1, m_pre2, m_ctrl, m_lock, m_en, m_key, m_stage;
  int          m_irq, m_tout, m_pulse, m_warm, m_aux;
  logic [31:0] m_cfg, m_rd;
  longint      m_cnt;

  function automatic longint span(input int p);
    if ((m_ctrl & 'h04) != 0) return longint'(p);
    return ((longint'(p) + 1) << SHIFT) - 1;
  endfunction

  function automatic logic [31:0] mread(input int w);
    case (w)
      0: return 32'(m_pre1);
      1: return 32'(m_pre2);
      3: return 32'((m_irq << 10) | (m_tout << 9));
      4: return 32'(m_ctrl);
      5: return m_cfg;
      6: return 32'((m_en << 1) | m_lock);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] mmerge(input logic [31:0] cur, input logic [31:0] d,
                                         input logic [3:0] be);
    logic [31:0] r;
    r = cur;
    for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = d[8*k +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pre1 = 0; m_pre2 = 0; m_ctrl = 0; m_lock = 0; m_en = 0; m_key = 0; m_stage = 1;
      m_irq = 0; m_tout = 0; m_pulse = 0; m_warm = 0; m_aux = 0; m_cfg = 0; m_rd = 0; m_cnt = 0;
    end else begin
      int  w, ok, rl, cl, oldctrl, oldlock;
      logic [31:0] rd;
      w = int'(bus_word);
      rd = mread(w);
      ok = (m_key == 2) ? 1 : 0;
      rl = (bus_we && w == 3 && bus_be[1] && ok == 1) ? 1 : 0;
      oldctrl = m_ctrl;
      oldlock = m_lock;
      if (m_pulse > 0) m_pulse--;
      if (rl == 1 && bus_wdata[9]) m_tout = 0;
      if (m_en == 0 || (rl == 1 && bus_wdata[8])) begin
        if (rl == 1 && bus_wdata[8]) m_irq = 0;
        m_cnt = span(m_pre1); m_stage = 1;
      end else if (m_cnt == 0) begin
        if (m_stage == 1) begin
          m_irq = 1; m_cnt = span(m_pre2); m_stage = 2;
        end else begin
          m_tout = 1;
          if ((oldctrl & 'h10) != 0) begin m_pulse = RSTC; m_warm = ((oldctrl & 'h08) != 0) ? 1 : 0; end
          if ((oldctrl & 'h20) == 0) m_aux = 1 - m_aux;
          m_cnt = span(m_pre1); m_stage = 1;
        end
      end else begin
        m_cnt--;
      end
      if (bus_we) begin
        if (w == 0 && ok == 1) m_pre1 = int'(mmerge(32'(m_pre1), bus_wdata, bus_be) & 32'hFFFFF);
        if (w == 1 && ok == 1) m_pre2 = int'(mmerge(32'(m_pre2), bus_wdata, bus_be) & 32'hFFFFF);
        if (w == 5) m_cfg = mmerge(m_cfg, bus_wdata, bus_be);
        if (w == 4 && bus_be[0] && oldlock == 0) m_ctrl = int'(bus_wdata & 32'h3C);
        if (w == 6 && bus_be[0] && oldlock == 0) begin
          m_lock = int'(bus_wdata[0]); m_en = int'(bus_wdata[1]);
        end
        if (w == 3 && bus_be == 4'b0001 && bus_wdata[7:0] == 8'h80) m_key = 1;
        else if (w == 3 && bus_be == 4'b0001 && bus_wdata[7:0] == 8'h86 && m_key == 1) m_key = 2;
        else m_key = 0;
      end
      m_rd = rd;
    end
  end

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && cmp_on) begin
      chk("R6 stage1_irq_o", 32'(stage1_irq_o), 32'(m_irq));
      chk("R7 timeout_o", 32'(timeout_o), 32'(m_tout));
      chk("R7 rst_req_o", 32'(rst_req_o), 32'(m_pulse > 0));
      chk("R7 rst_warm_o", 32'(rst_warm_o), 32'(m_pulse > 0 && m_warm == 1));
      chk("R7 aux_o", 32'(aux_o), 32'(m_aux));
      chk("R10 bus_rdata", bus_rdata, m_rd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int w, input logic [31:0] d, input logic [3:0] be);
    bus_word = 3'(w); bus_wdata = d; bus_be = be; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic unlock();
    wr(3, 32'h80, 4'b0001);
    wr(3, 32'h86, 4'b0001);
  endtask

  task automatic rd(input int w, input logic [31:0] exp, input string tag);
    bus_word = 3'(w); bus_we = 1'b0;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired, run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 irq", 32'(stage1_irq_o), 0);
    chk("R1 timeout", 32'(timeout_o), 0);
    chk("R1 rst_req", 32'(rst_req_o), 0);
    chk("R1 aux", 32'(aux_o), 0);
    chk("R1 rdata", bus_rdata, 0);
    cmp_on = 1'b1;
    rd(6, 32'h0, "R1 lock word");

    // R2: preload write without key is dropped
    wr(0, 32'h5, 4'hF);
    rd(0, 32'h0, "R2 preload1 without key");
    unlock(); wr(0, 32'h3, 4'hF);
    unlock(); wr(1, 32'h2, 4'hF);
    rd(0, 32'h3, "R2 preload1 after key");
    rd(1, 32'h2, "R2 preload2 after key");

    wr(4, 32'h10, 4'b0001);
    rd(4, 32'h10, "R10 control readback");

    // R5/R6: enable, stage one lasts (3+1)*4 = 16 cycles
    wr(6, 32'h2, 4'b0001);
    idle(15);
    chk("R5 stage1 not yet over", 32'(stage1_irq_o), 0);
    idle(1);
    chk("R5 stage1 over at 16", 32'(stage1_irq_o), 1);
    // stage two lasts 12 cycles -> timeout after edge 28; check at 30
    idle(14);
    chk("R7 timeout set", 32'(timeout_o), 1);
    chk("R7 reset pulse", 32'(rst_req_o), 1);
    chk("R7 cold reset", 32'(rst_warm_o), 0);
    chk("R7 aux toggled", 32'(aux_o), 1);

    // R2: clear without key is ignored
    wr(3, 32'h200, 4'b0010);
    chk("R2 clear without key ignored", 32'(timeout_o), 1);
    // R4: restart and clear together
    unlock(); wr(3, 32'h300, 4'b0010);
    chk("R4 timeout cleared", 32'(timeout_o), 0);
    chk("R4 stage1 flag cleared", 32'(stage1_irq_o), 0);

    // R3: broken key sequence
    wr(3, 32'h80, 4'b0001);
    wr(4, 32'h10, 4'b0001);
    wr(3, 32'h86, 4'b0001);
    wr(0, 32'h9, 4'hF);
    rd(0, 32'h3, "R3 interrupted key");
    wr(3, 32'h80, 4'b0001);
    wr(3, 32'h85, 4'b0001);
    wr(0, 32'h9, 4'hF);
    rd(0, 32'h3, "R3 wrong key value");
    unlock(); wr(0, 32'h7, 4'hF);
    wr(0, 32'h9, 4'hF);
    rd(0, 32'h7, "R3 key used up");

    // R5/R7: unscaled range, warm reset, no toggle
    wr(4, 32'h3C, 4'b0001);
    a0 = aux_o;
    unlock(); wr(3, 32'h100, 4'b0010);
    idle(7);
    chk("R5 fast stage1 not yet over", 32'(stage1_irq_o), 0);
    idle(1);
    chk("R5 fast stage1 over at 8", 32'(stage1_irq_o), 1);
    idle(3);
    chk("R7 fast timeout", 32'(timeout_o), 1);
    chk("R7 warm reset", 32'(rst_warm_o), 1);
    chk("R7 toggle disabled", 32'(aux_o), 32'(a0));

    // R8: disable stops the timer
    wr(6, 32'h0, 4'b0001);
    unlock(); wr(3, 32'h200, 4'b0010);
    idle(50);
    chk("R8 no timeout while off", 32'(timeout_o), 0);
    chk("R8 no reset while off", 32'(rst_req_o), 0);
    chk("R8 flag held while off", 32'(stage1_irq_o), 1);
    rd(6, 32'h0, "R8 enable readback");

    // R9: lock freezes enable and control
    wr(6, 32'h3, 4'b0001);
    wr(6, 32'h0, 4'b0001);
    rd(6, 32'h3, "R9 disable refused while locked");
    wr(4, 32'h0, 4'b0001);
    rd(4, 32'h3C, "R9 control frozen");
    idle(12);
    chk("R9 timer still running", 32'(timeout_o), 1);

    // R10: configuration word with lanes
    wr(5, 32'hA5A51234, 4'hF);
    rd(5, 32'hA5A51234, "R10 config full write");
    wr(5, 32'h0000FF00, 4'b0010);
    rd(5, 32'hA5A5FF34, "R10 config lane write");
    rd(7, 32'h0, "R10 unmapped word");
    idle(40);

    cmp_on = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule